// File: doc/BRIEF.md
# Physical Register Reference Counter

This block keeps a small counter for each physical register. The counter holds the number of architectural mappings that currently point at that register. With these counters, move elimination can let one physical register stand behind several mappings. The rename stage pulses allocate ports when a mapping starts to use a register and deallocate ports when a mapping stops using it. Several ports of each kind can fire in one cycle, and two or more of them may name the same register.

When a register's count drops from a non-zero value to zero, its index is handed to the free list. The zero check and the choice of the releasing port are registered before they leave the block. The release outputs therefore come one cycle after the request, which keeps the deallocate ports off the combinational path into the free list. Register 0 is never counted and never released.

On a flush, the block reloads every counter from a committed snapshot that is presented on a wide bulk-load port.

Top module: `prf_refcount`

## Requirements
- R1: After reset, registers 1 to 31 hold a count of one and every other register holds zero. The release valids and the error flag are low.
- R2: Each valid allocate port adds one to the count of the register it names. Each valid deallocate port subtracts one.
- R3: A register is released only in a cycle where its count moves from non-zero to zero. Lowering a count that stays above zero releases nothing.
- R4: A release shows up in the cycle after the deallocate request. It appears on the release slot with the same number as the deallocate port that caused it: `rel_vld[p]`, with the index in bits `p*IW +: IW` of `rel_idx`.
- R5: Register 0 is never counted. Allocating or deallocating it releases nothing and raises no error.
- R6: When several ports name the same register in one cycle, they add up to a single net change. For example, one allocate and one deallocate on a register with count one leave it at one, and nothing is released.
- R7: A count saturates at 7. A net decrement larger than the current count clamps the count to 0 and pulses `err` high in the following cycle.
- R8: When several deallocate ports name a register that reaches zero, only the lowest-numbered of those ports releases it.
- R9: A cycle with `flush` high loads every count from `snap_cnt` (register r in bits `r*3 +: 3`). That cycle ignores the allocate and deallocate ports, and the cycle after it shows no release and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alloc_vld | input | NPORT | Allocate request valids |
| alloc_idx | input | NPORT*IW | Register index for each allocate port |
| dealloc_vld | input | NPORT | Deallocate request valids |
| dealloc_idx | input | NPORT*IW | Register index for each deallocate port |
| flush | input | 1 | Restore counts from the snapshot |
| snap_cnt | input | NPREG*CW | Committed snapshot of all counts |
| rel_vld | output | NPORT | Release valid, one per deallocate port |
| rel_idx | output | NPORT*IW | Released register index per slot |
| err | output | 1 | Underflow seen in the previous cycle |

## Verification
A wrong count cannot be seen directly. It shows up when the register concerned is released too early or too late, or when it underflows where it should not. The bench therefore drives counts down to zero on purpose: at reset boundaries, after saturation, after same-cycle mixed traffic and after a snapshot reload. A wrong port choice or a missing delay stage is visible at the ports in the cycle right after the request, because the release slot or its timing is wrong. A bad count held in state can stay hidden for many cycles, until that register's last deallocation.

// File: rtl/prf_refcount.sv
module prf_refcount #(
  parameter int NPREG    = 64,
  parameter int NPORT    = 4,
  parameter int CW       = 3,
  parameter int INIT_CNT = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORT-1:0]      alloc_vld,
  input  logic [NPORT*$clog2(NPREG)-1:0] alloc_idx,
  input  logic [NPORT-1:0]      dealloc_vld,
  input  logic [NPORT*$clog2(NPREG)-1:0] dealloc_idx,
  input  logic                  flush,
  input  logic [NPREG*CW-1:0]   snap_cnt,
  output logic [NPORT-1:0]      rel_vld,
  output logic [NPORT*$clog2(NPREG)-1:0] rel_idx,
  output logic                  err
);
  localparam int IW    = $clog2(NPREG);
  localparam int NSLOT = 1 << IW;
  localparam int PW    = $clog2(NPORT + 1);
  localparam int SW    = CW + PW + 1;
  localparam logic [SW-1:0] CMAX = SW'((1 << CW) - 1);

  logic [CW-1:0]    cnt [NPREG];
  logic [CW-1:0]    nxt [NPREG];
  logic [NSLOT-1:0] freed;
  logic [NPREG-1:0] under;
  logic [NPORT-1:0] rel_d;

  always_comb begin
    freed = '0;
    under = '0;
    nxt[0] = '0;
    for (int r = 1; r < NPREG; r++) begin
      logic [SW-1:0] sum, dec;
      sum = SW'(cnt[r]);
      dec = '0;
      for (int p = 0; p < NPORT; p++) begin
        if (alloc_vld[p] && alloc_idx[p*IW +: IW] == IW'(r))
          sum = sum + SW'(1);
        if (dealloc_vld[p] && dealloc_idx[p*IW +: IW] == IW'(r))
          dec = dec + SW'(1);
      end
      if (dec > sum) begin
        under[r] = 1'b1;
        nxt[r] = '0;
      end else if (sum - dec > CMAX) begin
        nxt[r] = CMAX[CW-1:0];
      end else begin
        nxt[r] = CW'(sum - dec);
      end
      freed[r] = (cnt[r] != '0) && (nxt[r] == '0);
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      logic [IW-1:0] id;
      logic          dup;
      id  = dealloc_idx[p*IW +: IW];
      dup = 1'b0;
      for (int q = 0; q < p; q++)
        if (dealloc_vld[q] && dealloc_idx[q*IW +: IW] == id) dup = 1'b1;
      rel_d[p] = dealloc_vld[p] && (id != '0) && freed[id] && !dup;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NPREG; r++)
        cnt[r] <= (r >= 1 && r < INIT_CNT) ? CW'(1) : '0;
      rel_vld <= '0;
      rel_idx <= '0;
      err     <= 1'b0;
    end else if (flush) begin
      cnt[0] <= '0;
      for (int r = 1; r < NPREG; r++)
        cnt[r] <= snap_cnt[r*CW +: CW];
      rel_vld <= '0;
      err     <= 1'b0;
    end else begin
      for (int r = 0; r < NPREG; r++)
        cnt[r] <= nxt[r];
      rel_vld <= rel_d;
      rel_idx <= dealloc_idx;
      err     <= |under;
    end
  end
endmodule

// File: rtl/prf_refcount_chk.sv
module prf_refcount_chk #(
  parameter int NPREG = 64,
  parameter int NPORT = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NPORT-1:0]      dealloc_vld,
  input logic [NPORT*$clog2(NPREG)-1:0] dealloc_idx,
  input logic                  flush,
  input logic [NPORT-1:0]      rel_vld,
  input logic [NPORT*$clog2(NPREG)-1:0] rel_idx,
  input logic                  err
);
  localparam int IW = $clog2(NPREG);

  p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> (rel_vld == '0 && !err));

  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(|dealloc_vld));

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    p_no_reg0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rel_vld[p] |-> rel_idx[p*IW +: IW] != '0);

    p_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rel_vld[p] |-> ($past(dealloc_vld[p]) &&
                      rel_idx[p*IW +: IW] == $past(dealloc_idx[p*IW +: IW])));

    for (genvar q = p + 1; q < NPORT; q++) begin : g_pair
      p_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_vld[p] && rel_vld[q]) |-> rel_idx[p*IW +: IW] != rel_idx[q*IW +: IW]);
    end
  end
endmodule

bind prf_refcount prf_refcount_chk #(.NPREG(NPREG), .NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .dealloc_vld(dealloc_vld), .dealloc_idx(dealloc_idx),
  .flush(flush), .rel_vld(rel_vld), .rel_idx(rel_idx), .err(err)
);

// File: tb/prf_refcount_test.sv
`timescale 1ns/1ps
module prf_refcount_test;
  localparam int NPREG = 64, NPORT = 4, CW = 3, IW = 6;

  logic clk = 0, rst_n = 0;
  logic [NPORT-1:0] alloc_vld = '0, dealloc_vld = '0;
  logic [NPORT*IW-1:0] alloc_idx = '0, dealloc_idx = '0;
  logic flush = 0;
  logic [NPREG*CW-1:0] snap_cnt = '0;
  logic [NPORT-1:0] rel_vld;
  logic [NPORT*IW-1:0] rel_idx;
  logic err;

  prf_refcount uut (.*);

  always #2 clk = ~clk;

  typedef struct { logic [NPORT-1:0] vld; logic [NPORT*IW-1:0] idx; logic er; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  int mc [NPREG];
  bit done = 0;

  function automatic logic [NPORT*IW-1:0] pk(int a, int b, int c, int d);
    return {IW'(d), IW'(c), IW'(b), IW'(a)};
  endfunction

  task automatic cyc(input logic [3:0] av, input logic [23:0] ai,
                     input logic [3:0] dv, input logic [23:0] di,
                     input logic fl, input string tag);
    exp_t e;
    int nx [NPREG];
    bit fr [NPREG];
    @(negedge clk);
    alloc_vld = av; alloc_idx = ai; dealloc_vld = dv; dealloc_idx = di; flush = fl;
    e.vld = '0; e.idx = di; e.er = 0; e.tag = tag;
    if (fl) begin
      for (int r = 1; r < NPREG; r++) mc[r] = int'(snap_cnt[r*CW +: CW]);
    end else begin
      for (int r = 1; r < NPREG; r++) begin
        int up = 0, dn = 0;
        for (int p = 0; p < NPORT; p++) begin
          if (av[p] && int'(ai[p*IW +: IW]) == r) up++;
          if (dv[p] && int'(di[p*IW +: IW]) == r) dn++;
        end
        if (dn > mc[r] + up) begin e.er = 1; nx[r] = 0; end
        else nx[r] = (mc[r] + up - dn > 7) ? 7 : mc[r] + up - dn;
        fr[r] = (mc[r] != 0) && (nx[r] == 0);
      end
      for (int p = 0; p < NPORT; p++) begin
        int id = int'(di[p*IW +: IW]);
        bit first = 1;
        for (int k = 0; k < p; k++)
          if (dv[k] && int'(di[k*IW +: IW]) == id) first = 0;
        e.vld[p] = dv[p] && id != 0 && fr[id] && first;
      end
      for (int r = 1; r < NPREG; r++) mc[r] = nx[r];
    end
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    cyc(4'b0, '0, 4'b0, '0, 1'b0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    bit bad;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        bad = (rel_vld !== e.vld) || (err !== e.er);
        for (int p = 0; p < NPORT; p++)
          if (e.vld[p] && rel_idx[p*IW +: IW] !== e.idx[p*IW +: IW]) bad = 1;
        checks++;
        if (bad) begin
          fails++;
          $display("FAIL %s: rel_vld=%b rel_idx=%h err=%b expected rel_vld=%b rel_idx=%h err=%b",
                   e.tag, rel_vld, rel_idx, err, e.vld, e.idx, e.er);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NPREG; r++) mc[r] = (r >= 1 && r < 32) ? 1 : 0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rel_vld !== '0 || err !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs: rel_vld=%b err=%b expected 0 0", rel_vld, err);
    end
    @(negedge clk); rst_n = 1;

    idle("R1 idle after reset");
    cyc(0, '0, 4'b0001, pk(31,0,0,0), 0, "R1 reg31 starts at one");
    cyc(0, '0, 4'b0001, pk(32,0,0,0), 0, "R1 R7 reg32 starts at zero, underflow");
    idle("R7 err is a single pulse");
    cyc(0, '0, 4'b0001, pk(5,0,0,0), 0, "R3 R4 reg5 released");
    cyc(0, '0, 4'b1111, pk(1,2,3,4), 0, "R4 four releases in one cycle");
    cyc(4'b0011, pk(40,40,0,0), 0, '0, 0, "R2 alloc reg40 twice");
    cyc(0, '0, 4'b0001, pk(40,0,0,0), 0, "R3 reg40 2->1 no release");
    cyc(0, '0, 4'b0100, pk(0,0,40,0), 0, "R3 R4 reg40 1->0 on slot 2");
    cyc(4'b0001, pk(10,0,0,0), 4'b0001, pk(10,0,0,0), 0, "R6 alloc+dealloc reg10 net zero");
    cyc(0, '0, 4'b0010, pk(0,10,0,0), 0, "R6 reg10 still one, released now");
    cyc(4'b0001, pk(12,0,0,0), 0, '0, 0, "R2 reg12 to two");
    cyc(0, '0, 4'b0110, pk(0,12,12,0), 0, "R8 first port only releases reg12");
    cyc(4'b0001, pk(0,0,0,0), 4'b1111, pk(0,0,0,0), 0, "R5 reg0 untouched");
    cyc(4'b1111, pk(50,50,50,50), 0, '0, 0, "R7 reg50 to four");
    cyc(4'b1111, pk(50,50,50,50), 0, '0, 0, "R7 reg50 saturates");
    cyc(0, '0, 4'b1111, pk(50,50,50,50), 0, "R7 reg50 7->3");
    cyc(0, '0, 4'b1110, pk(0,50,50,50), 0, "R7 R8 reg50 3->0 released once");
    cyc(0, '0, 4'b0011, pk(20,20,0,0), 0, "R7 underflow reg20 with release");
    for (int r = 1; r < NPREG; r++) snap_cnt[r*CW +: CW] = (r < 32) ? 3'd1 : 3'd0;
    snap_cnt[20*CW +: CW] = 3'd2;
    snap_cnt[25*CW +: CW] = 3'd0;
    cyc(4'b0001, pk(25,0,0,0), 4'b0001, pk(7,0,0,0), 1, "R9 flush ignores ports");
    cyc(0, '0, 4'b0001, pk(20,0,0,0), 0, "R9 reg20 restored to two");
    cyc(0, '0, 4'b0011, pk(20,7,0,0), 0, "R9 reg20 and reg7 released");
    cyc(0, '0, 4'b0001, pk(25,0,0,0), 0, "R9 reg25 restored to zero");
    idle("tail");
    idle("tail");
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule